// File: doc/BRIEF.md
# RMII Receive Di-bit Serializer

This block drives the receive half of a Reduced MII link from the PHY side. A show-ahead byte FIFO holds the decoded receive bytes. The block also takes a carrier indication and an error flag from the line decoder, and a rate select. It turns the bytes into the two-bit receive bus and generates the combined carrier-sense / data-valid line. Both outputs are registered and timed by the reference clock.

When carrier appears, the valid line rises at once and the data pair idles at 00 until the first byte is taken. Bytes leave least-significant pair first. In the fast rate a new pair is presented on every clock. In the slow rate each pair is held for ten clocks. After carrier has gone, the valid line is pulled low during the first pair of each byte still waiting in the FIFO and is raised again for the rest of that byte. It stays low once the FIFO is empty. A decode error turns the data pair into the fault code 10 for the rest of the activity and discards any bytes still queued.

Top module: `rmii_rx_dibit_tx`

## Requirements
- R1: A synchronous active-high reset returns the block to idle: after the reset edge `rxd` is 00, `crs_dv` is 0 and `fifo_rd` is 0.
- R2: From idle, `carrier_in` sampled high makes `crs_dv` 1 after that same edge, with `rxd` at 00. That 00 pair lasts one full pair slot before the first byte is taken.
- R3: Each byte is sent as bits [1:0], [3:2], [5:4] and then [7:6]. A frame that starts with the preamble byte 0x55 therefore shows 01 (bit 1 = 0, bit 0 = 1) as its first non-idle pair. `fifo_rd` is high for one cycle per byte taken and only when `fifo_empty` is 0.
- R4: With `speed_10m` = 0 a pair slot lasts one clock, so each byte occupies four consecutive cycles.
- R5: With `speed_10m` = 1 a pair slot lasts SLOW_DIV (10) clocks. Apart from an error, `rxd` changes only at slot boundaries.
- R6: Once `carrier_in` has been sampled low during an activity, `crs_dv` is 0 during the slot of bits [1:0] of every byte still being sent, and 1 during its other three slots.
- R7: When a new byte is due but the FIFO is empty, `rxd` is 00. If carrier has not gone, `crs_dv` stays 1. At the first slot boundary where carrier has gone and the FIFO is empty, `crs_dv` falls to 0 and the block returns to idle.
- R8: `error_in` sampled high during an activity makes `rxd` 10 from the next edge, with `crs_dv` 1. Queued bytes are then popped and discarded one per cycle. The block returns to idle at the first slot boundary where carrier has gone and the FIFO is empty.
- R9: `error_in` is ignored while idle: the outputs stay 00 / 0 and no byte is popped.
- R10: If `error_in` is sampled at the same edge as a byte load or as the end of a frame, the error wins. No byte is taken at that edge and `rxd` becomes 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| speed_10m | input | 1 | 1 selects the slow rate, 0 the fast rate |
| carrier_in | input | 1 | Receive carrier from the line decoder |
| error_in | input | 1 | False carrier or symbol error flag |
| fifo_data | input | BYTE_W | Head byte of the receive FIFO (show-ahead) |
| fifo_empty | input | 1 | FIFO holds no byte |
| fifo_rd | output | 1 | Pops the head byte at this clock edge |
| rxd | output | 2 | Receive di-bit to the MAC |
| crs_dv | output | 1 | Combined carrier sense / data valid |

## Verification
Two functions can land on the same clock edge: the end-of-carrier marking of `crs_dv`, and the loading of the next byte or the end-of-frame decision. The error takeover can also collide with either of them. The bench drops carrier on exactly the edge that loads a new byte, and it raises the error flag on exactly the edge where the frame would otherwise end. It then compares every cycle of `rxd` and `crs_dv` against a model built from the slot arithmetic in the requirements. It also checks that the FIFO read pointer has drained.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;

    typedef logic [1:0] dibit_t;

    localparam dibit_t DIBIT_QUIET = 2'b00;
    localparam dibit_t DIBIT_FAULT = 2'b10;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_ERR  = 2'd2
    } rx_state_e;

    // command from the sequencer to the byte holder
    typedef struct packed {
        logic load;
        logic adv;
        logic clear;
    } shift_cmd_t;

    // registered line state toward the MAC
    typedef struct packed {
        dibit_t data;
        logic   dv;
    } line_t;

    localparam line_t LINE_OFF = '{data: DIBIT_QUIET, dv: 1'b0};

    function automatic int pacer_width(input int div);
        return (div < 2) ? 1 : $clog2(div);
    endfunction

endpackage

// File: rtl/rmii_rx_pacer.sv
module rmii_rx_pacer
    import rmii_rx_pkg::*;
#(
    parameter int SLOW_DIV = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic slow,
    output logic tick
);

    localparam int CNT_W = pacer_width(SLOW_DIV);
    localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_DIV - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    assign limit = slow ? SLOW_LAST : '0;
    assign tick  = run && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q <= SLOW_LAST)) else $error("slot counter overran"); // R5

endmodule

// File: rtl/rmii_rx_shifter.sv
module rmii_rx_shifter
    import rmii_rx_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  shift_cmd_t        cmd,
    input  logic [BYTE_W-1:0] din,
    output logic              full,
    output logic              last,
    output dibit_t            next_dibit
);

    localparam int PAIRS = BYTE_W / 2;
    localparam int PH_W  = (PAIRS < 2) ? 1 : $clog2(PAIRS);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PAIRS - 1);

    logic [BYTE_W-1:0] byte_q;
    logic [PH_W-1:0]   phase_q;
    logic              full_q;
    logic [PH_W-1:0]   phase_nx;

    assign phase_nx   = phase_q + 1'b1;
    assign next_dibit = byte_q[{phase_nx, 1'b0} +: 2];
    assign full       = full_q;
    assign last       = full_q && (phase_q == PH_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_q  <= '0;
            phase_q <= '0;
            full_q  <= 1'b0;
        end else if (cmd.load) begin
            byte_q  <= din;
            phase_q <= '0;
            full_q  <= 1'b1;
        end else if (cmd.adv) begin
            phase_q <= phase_nx;
        end else if (cmd.clear) begin
            phase_q <= '0;
            full_q  <= 1'b0;
        end
    end

    AST_ADV_INSIDE_BYTE: assert property (@(posedge clk) disable iff (rst)
        cmd.adv |-> (full_q && !last)) else $error("advance past byte end"); // R3

endmodule

// File: rtl/rmii_rx_ctrl.sv
module rmii_rx_ctrl
    import rmii_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       carrier_in,
    input  logic       error_in,
    input  logic       fifo_empty,
    input  dibit_t     fifo_dibit0,
    input  logic       tick,
    input  logic       sh_full,
    input  logic       sh_last,
    input  dibit_t     sh_next,
    output shift_cmd_t cmd,
    output logic       pop,
    output logic       running,
    output dibit_t     rxd,
    output logic       crs_dv
);

    rx_state_e state_q, state_nx;
    line_t     line_q, line_nx;
    logic      gone_q, gone_nx;
    logic      gone_now;
    logic      need_byte;

    assign gone_now  = gone_q || !carrier_in;
    assign need_byte = !sh_full || sh_last;

    always_comb begin
        state_nx = state_q;
        line_nx  = line_q;
        gone_nx  = gone_q;
        cmd      = '0;
        pop      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                line_nx   = LINE_OFF;
                gone_nx   = 1'b0;
                cmd.clear = 1'b1;
                if (carrier_in) begin
                    state_nx   = ST_RUN;
                    line_nx.dv = 1'b1;
                end
            end
            ST_RUN: begin
                gone_nx = gone_now;
                if (error_in) begin
                    state_nx  = ST_ERR;
                    line_nx   = '{data: DIBIT_FAULT, dv: 1'b1};
                    cmd.clear = 1'b1;
                end else if (tick) begin
                    if (!need_byte) begin
                        cmd.adv = 1'b1;
                        line_nx = '{data: sh_next, dv: 1'b1};
                    end else if (!fifo_empty) begin
                        pop      = 1'b1;
                        cmd.load = 1'b1;
                        line_nx  = '{data: fifo_dibit0, dv: !gone_now};
                    end else begin
                        cmd.clear = 1'b1;
                        if (gone_now) begin
                            state_nx = ST_IDLE;
                            line_nx  = LINE_OFF;
                            gone_nx  = 1'b0;
                        end else begin
                            line_nx = '{data: DIBIT_QUIET, dv: 1'b1};
                        end
                    end
                end
            end
            ST_ERR: begin
                gone_nx   = gone_now;
                pop       = !fifo_empty;
                cmd.clear = 1'b1;
                line_nx   = '{data: DIBIT_FAULT, dv: 1'b1};
                if (tick && gone_now && fifo_empty) begin
                    state_nx = ST_IDLE;
                    line_nx  = LINE_OFF;
                    gone_nx  = 1'b0;
                end
            end
            default: begin
                state_nx = ST_IDLE;
                line_nx  = LINE_OFF;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            line_q  <= LINE_OFF;
            gone_q  <= 1'b0;
        end else begin
            state_q <= state_nx;
            line_q  <= line_nx;
            gone_q  <= gone_nx;
        end
    end

    assign running = (state_q != ST_IDLE);
    assign rxd     = line_q.data;
    assign crs_dv  = line_q.dv;

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (rxd == DIBIT_QUIET && !crs_dv)) else $error("reset left line active"); // R1

    AST_CARRIER_RISE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && carrier_in) |=> (crs_dv && rxd == DIBIT_QUIET)) else $error("valid did not rise"); // R2

    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        pop |-> !fifo_empty) else $error("pop from empty fifo"); // R3

    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && !tick && !error_in) |=> $stable(rxd)) else $error("pair changed mid slot"); // R5

    AST_FAULT_CODE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && error_in) |=> (rxd == DIBIT_FAULT && crs_dv)) else $error("fault code missing"); // R8

    AST_IDLE_DEAF: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !carrier_in) |=> (!crs_dv && rxd == DIBIT_QUIET)) else $error("idle line disturbed"); // R9

endmodule

// File: rtl/rmii_rx_dibit_tx.sv
module rmii_rx_dibit_tx
    import rmii_rx_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter int SLOW_DIV = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              speed_10m,
    input  logic              carrier_in,
    input  logic              error_in,
    input  logic [BYTE_W-1:0] fifo_data,
    input  logic              fifo_empty,
    output logic              fifo_rd,
    output logic [1:0]        rxd,
    output logic              crs_dv
);

    logic       tick;
    logic       running;
    shift_cmd_t cmd;
    logic       sh_full;
    logic       sh_last;
    dibit_t     sh_next;

    rmii_rx_pacer #(.SLOW_DIV(SLOW_DIV)) u_pacer (
        .clk  (clk),
        .rst  (rst),
        .run  (running),
        .slow (speed_10m),
        .tick (tick)
    );

    rmii_rx_shifter #(.BYTE_W(BYTE_W)) u_shifter (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .din        (fifo_data),
        .full       (sh_full),
        .last       (sh_last),
        .next_dibit (sh_next)
    );

    rmii_rx_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .carrier_in  (carrier_in),
        .error_in    (error_in),
        .fifo_empty  (fifo_empty),
        .fifo_dibit0 (fifo_data[1:0]),
        .tick        (tick),
        .sh_full     (sh_full),
        .sh_last     (sh_last),
        .sh_next     (sh_next),
        .cmd         (cmd),
        .pop         (fifo_rd),
        .running     (running),
        .rxd         (rxd),
        .crs_dv      (crs_dv)
    );

endmodule

// File: tb/rmii_rx_dibit_tx_bench.sv
module rmii_rx_dibit_tx_bench;

    typedef struct packed {
        logic       slow;
        logic [3:0] nb;
        logic [9:0] drop;
        logic [9:0] err;   // 0 means no error
        logic [7:0] seed;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 4'd3, 10'd2,   10'd0,  8'hA3},
        '{1'b0, 4'd2, 10'd20,  10'd0,  8'h3C},
        '{1'b0, 4'd4, 10'd5,   10'd0,  8'hE7},
        '{1'b1, 4'd2, 10'd15,  10'd0,  8'h5A},
        '{1'b1, 4'd1, 10'd100, 10'd0,  8'hC1},
        '{1'b0, 4'd3, 10'd30,  10'd6,  8'h99},
        '{1'b1, 4'd2, 10'd12,  10'd25, 8'h0F},
        '{1'b0, 4'd0, 10'd3,   10'd0,  8'h00},
        '{1'b0, 4'd2, 10'd9,   10'd9,  8'h71}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       speed_10m = 1'b0;
    logic       carrier_in = 1'b0;
    logic       error_in = 1'b0;
    logic [7:0] fifo_data;
    logic       fifo_empty;
    logic       fifo_rd;
    logic [1:0] rxd;
    logic       crs_dv;

    logic [7:0] mem [16];
    logic [7:0] wr_ptr = 8'd0;
    logic [7:0] rd_ptr = 8'd0;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    assign fifo_empty = (rd_ptr == wr_ptr);
    assign fifo_data  = mem[rd_ptr[3:0]];

    always @(posedge clk) begin
        if (fifo_rd) rd_ptr <= rd_ptr + 8'd1;
    end

    rmii_rx_dibit_tx u_rmii_rx_dibit_tx (
        .clk        (clk),
        .rst        (rst),
        .speed_10m  (speed_10m),
        .carrier_in (carrier_in),
        .error_in   (error_in),
        .fifo_data  (fifo_data),
        .fifo_empty (fifo_empty),
        .fifo_rd    (fifo_rd),
        .rxd        (rxd),
        .crs_dv     (crs_dv)
    );

    function automatic logic [7:0] byte_of(input logic [7:0] seed, input int b);
        return (b == 0) ? 8'h55 : seed + 8'(b * 53);
    endfunction

    // first edge (counted from the carrier edge) at which the frame is idle again
    function automatic int end_edge(input vec_t v);
        int len = v.slow ? 10 : 1;
        int s;
        int popped = 0;
        if (v.err != 0) begin
            for (int b = 0; b < int'(v.nb); b++)
                if ((4 * b + 1) * len < int'(v.err)) popped++;
            s = 1;
            while (s * len < int'(v.err) + (int'(v.nb) - popped) + 1 || s * len < int'(v.drop)) s++;
        end else begin
            s = 4 * int'(v.nb) + 1;
            while (s * len < int'(v.drop)) s++;
        end
        return s * len;
    endfunction

    function automatic void expect_at(input int t, input vec_t v,
                                      output logic [1:0] er, output logic ec,
                                      output string tag);
        int len = v.slow ? 10 : 1;
        int s = t / len;
        int x = end_edge(v);
        int b;
        int p;
        logic [7:0] d;
        if (v.err != 0 && t >= int'(v.err)) begin
            tag = (v.err == v.drop) ? "R10" : "R8";
            if (t < x) begin er = 2'b10; ec = 1'b1; end
            else       begin er = 2'b00; ec = 1'b0; end
        end else if (t >= x) begin
            tag = "R7"; er = 2'b00; ec = 1'b0;
        end else if (s == 0) begin
            tag = "R2"; er = 2'b00; ec = 1'b1;
        end else if (s <= 4 * int'(v.nb)) begin
            b  = (s - 1) / 4;
            p  = (s - 1) % 4;
            d  = byte_of(v.seed, b);
            er = d[2*p +: 2];
            ec = !(p == 0 && s * len >= int'(v.drop));
            if (!ec)         tag = "R6";
            else if (s == 1) tag = "R3";
            else if (v.slow) tag = "R5";
            else             tag = "R4";
        end else begin
            tag = "R7"; er = 2'b00; ec = 1'b1;
        end
    endfunction

    task automatic check_line(input string tag, input logic [1:0] er, input logic ec);
        checks++;
        if (rxd !== er || crs_dv !== ec) begin
            fails++;
            $display("FAIL %s t=%0t rxd=%b crs_dv=%b expected rxd=%b crs_dv=%b",
                     tag, $time, rxd, crs_dv, er, ec);
        end
    endtask

    task automatic run_frame(input vec_t v);
        logic [1:0] er;
        logic       ec;
        string      tag;
        int         last_t;
        @(negedge clk);
        for (int b = 0; b < int'(v.nb); b++) begin
            mem[wr_ptr[3:0]] = byte_of(v.seed, b);
            wr_ptr = wr_ptr + 8'd1;
        end
        speed_10m  = v.slow;
        carrier_in = 1'b1;
        error_in   = 1'b0;
        last_t     = end_edge(v) + 2;
        for (int t = 0; t <= last_t; t++) begin
            @(posedge clk);
            @(negedge clk);
            expect_at(t, v, er, ec, tag);
            check_line(tag, er, ec);
            carrier_in = (t + 1 < int'(v.drop));
            error_in   = (v.err != 0) && (t + 1 == int'(v.err));
        end
        carrier_in = 1'b0;
        error_in   = 1'b0;
        checks++;
        if (rd_ptr !== wr_ptr) begin
            fails++;
            $display("FAIL %s fifo not drained rd=%0d expected %0d",
                     (v.err != 0) ? "R8" : "R7", rd_ptr, wr_ptr);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_line("R1", 2'b00, 1'b0);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) run_frame(VECS[i]);

        // R9: error flag with no carrier while a byte waits
        @(negedge clk);
        mem[wr_ptr[3:0]] = 8'hD2;
        wr_ptr   = wr_ptr + 8'd1;
        error_in = 1'b1;
        for (int k = 0; k < 5; k++) begin
            @(posedge clk);
            @(negedge clk);
            check_line("R9", 2'b00, 1'b0);
            checks++;
            if (rd_ptr == wr_ptr) begin
                fails++;
                $display("FAIL R9 byte popped while idle rd=%0d expected %0d", rd_ptr, wr_ptr - 8'd1);
            end
        end
        error_in = 1'b0;

        // R1: reset in the middle of an activity
        carrier_in = 1'b1;
        speed_10m  = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_line("R1", 2'b00, 1'b0);
        checks++;
        if (fifo_rd !== 1'b0) begin
            fails++;
            $display("FAIL R1 fifo_rd=%b expected 0", fifo_rd);
        end
        carrier_in = 1'b0;
        rst = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            $display("FAIL watchdog expired after %0d cycles expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks + 1, fails + 1);
            $finish;
        end
    end

endmodule